// File: doc/BRIEF.md
# Region Access Guard

This block sits between the address generation of a small core that has no paging unit and its memory system. It validates every load, store and instruction fetch against a coarse protection map. The 4 GB address space is divided into eight equal 512 MB regions, and the top three address bits pick the region. Each region carries a 4-bit attribute code. That code yields read, write and execute permission together with a cache mode: write-through, write-back, bypass or isolate.

The attribute comes from one of two sources, chosen by a mode input. In table mode it comes from a small per-region table that also holds a physical base for the region, so the region is translated as well as checked. In word mode it comes from one nibble of a 32-bit cache-attribute word, and the address passes through unchanged.

Each request produces a registered response one cycle later. The response carries either the physical address or a nonzero cause code that names the kind of prohibited access. The table is written one entry at a time through a simple write strobe. Cache behaviour itself is outside this block.

Top module: `rgn_access_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid` is 0 after that edge. Reset loads every table entry i with physical base i and attribute code 2.
- R2: A response appears exactly one cycle after its request: `rsp_valid` equals `req_valid` from the previous edge.
- R3: The region index is `req_addr[31:29]`. In table mode (`tbl_mode`=1) entry index is used. In word mode (`tbl_mode`=0) the attribute is `cattr_word[4*index+3 : 4*index]`.
- R4: `rsp_cmode` encodes 0 none, 1 write-through, 2 write-back, 3 bypass, 4 isolate. The attribute codes decode as follows. Code 0 gives read and write, write-through. Code 1 gives read, write and execute, write-through. Code 2 gives read, write and execute, bypass. Code 3 gives execute only, write-back. Code 4 gives read, write and execute, write-back. Code 14 gives read and write, isolate.
- R5: Code 5 gives read, write and execute with write-back in table mode only. In word mode code 5, like every code not listed in R4, gives no permission and cache mode 0.
- R6: `req_kind` 0 is a load and needs read permission. Kind 1 is a store and needs write. Kind 2 is a fetch and needs execute. Kind 3 is handled as a load.
- R7: `rsp_cause` is 0 when the access is granted. A denied load reports 28, a denied store 29 and a denied fetch 20.
- R8: A granted access in table mode returns `{entry base, req_addr[28:0]}`. A granted access in word mode returns `req_addr` unchanged. A denied access returns 0.
- R9: When `cfg_we` is high at an edge, entry `cfg_idx` takes `cfg_base` and `cfg_attr`. Requests from the next cycle on see the new entry, and a request in the same cycle still sees the old one.
- R10: `rsp_rd`, `rsp_wr`, `rsp_ex` and `rsp_cmode` report the decoded attribute of the addressed region for every valid response, whether or not the access was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_mode | input | 1 | 1: attributes and bases from the region table; 0: attributes from the cache-attribute word |
| cattr_word | input | 32 | Eight attribute nibbles, nibble i for region i |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | 3 | Entry to write |
| cfg_base | input | 3 | New physical base (top three address bits) |
| cfg_attr | input | 4 | New attribute code |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address, 0 when denied |
| rsp_cause | output | 6 | 0 granted, 28 load, 29 store, 20 fetch prohibited |
| rsp_rd | output | 1 | Region readable |
| rsp_wr | output | 1 | Region writable |
| rsp_ex | output | 1 | Region executable |
| rsp_cmode | output | 3 | Cache mode of the region |

## Verification
The only internal state is the eight-entry table. A corrupted base or attribute therefore stays hidden until a request addresses that region, and it then shows in the very next response. It shows up as a wrong upper address, a wrong cache mode or a spurious cause. The bench sweeps every attribute code in both modes under every access kind. It also reads each entry back after a write, including a request issued in the same cycle as the write, so that a stale or early update appears within one cycle.

// File: rtl/rgn_guard_pkg.sv
// Shared types and the attribute decode for the region access guard.
// Assumes 4-bit attribute codes; the decode is the single place that
// maps a code to permissions and a cache mode.
package rgn_guard_pkg;

    typedef enum logic [2:0] {
        CM_NONE   = 3'd0,
        CM_WTHRU  = 3'd1,
        CM_WBACK  = 3'd2,
        CM_BYPASS = 3'd3,
        CM_ISOL   = 3'd4
    } cmode_e;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_FETCH = 2'd2,
        K_RSVD  = 2'd3
    } kind_e;

    typedef struct packed {
        logic   rd;
        logic   wr;
        logic   ex;
        cmode_e cm;
    } perm_t;

    localparam int CAUSE_W = 6;
    localparam logic [CAUSE_W-1:0] CAUSE_OK    = 6'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 6'd20;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 6'd28;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = 6'd29;

    // Map an attribute code to permissions; code 5 is honoured only for
    // table-sourced attributes.
    function automatic perm_t decode_attr(input logic [3:0] code, input logic from_tbl);
        perm_t p;
        p = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, cm: CM_NONE};
        case (code)
            4'd0:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_WTHRU};
            4'd1:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WTHRU};
            4'd2:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_BYPASS};
            4'd3:  p = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, cm: CM_WBACK};
            4'd4:  p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WBACK};
            4'd5:  if (from_tbl) p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, cm: CM_WBACK};
            4'd14: p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, cm: CM_ISOL};
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rgn_entry_table.sv
// Per-region table of physical base and attribute code.
// One entry written per cycle; reads are combinational. Assumes
// BASE_W == IDX_W so that reset can load an identity mapping.
module rgn_entry_table #(
    parameter int NUM_RGN = 8,
    parameter int IDX_W   = 3,
    parameter int BASE_W  = 3,
    parameter int ATTR_W  = 4,
    parameter logic [ATTR_W-1:0] RST_ATTR = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [ATTR_W-1:0] rd_attr
);

    logic [BASE_W-1:0] base_q [NUM_RGN];
    logic [ATTR_W-1:0] attr_q [NUM_RGN];

    for (genvar i = 0; i < NUM_RGN; i++) begin : g_ent
        localparam logic [BASE_W-1:0] RST_BASE = BASE_W'(i);
        // Hold one entry; reset to identity base and default attribute.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= RST_BASE;
                attr_q[i] <= RST_ATTR;
            end else if (we && (wr_idx == IDX_W'(i))) begin
                base_q[i] <= wr_base;
                attr_q[i] <= wr_attr;
            end
        end
    end

    // Read the addressed entry.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_attr = attr_q[rd_idx];
    end

endmodule

// File: rtl/rgn_attr_source.sv
// Chooses the attribute code for a region: table entry or the nibble
// of the cache-attribute word at position index*ATTR_W.
module rgn_attr_source #(
    parameter int NUM_RGN = 8,
    parameter int IDX_W   = 3,
    parameter int ATTR_W  = 4,
    localparam int WORD_W = NUM_RGN * ATTR_W
) (
    input  logic              tbl_mode,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] cattr_word,
    input  logic [ATTR_W-1:0] tbl_attr,
    output logic [ATTR_W-1:0] attr
);

    // Select the attribute source by mode.
    always_comb begin
        if (tbl_mode) attr = tbl_attr;
        else          attr = cattr_word[idx*ATTR_W +: ATTR_W];
    end

endmodule

// File: rtl/rgn_perm_check.sv
// Decodes the attribute and decides whether the access kind is allowed,
// producing the prohibited cause or zero. Kind 3 is handled as a load.
module rgn_perm_check
    import rgn_guard_pkg::*;
(
    input  logic [3:0]         attr,
    input  logic               from_tbl,
    input  logic [1:0]         kind,
    output perm_t              perm,
    output logic [CAUSE_W-1:0] cause
);

    // Decode permissions and pick the cause for the access kind.
    always_comb begin
        perm = decode_attr(attr, from_tbl);
        case (kind_e'(kind))
            K_STORE: cause = perm.wr ? CAUSE_OK : CAUSE_STORE;
            K_FETCH: cause = perm.ex ? CAUSE_OK : CAUSE_FETCH;
            default: cause = perm.rd ? CAUSE_OK : CAUSE_LOAD;
        endcase
    end

endmodule

// File: rtl/rgn_access_guard.sv
// Region access guard: checks a load, store or fetch against the
// attribute of its 512 MB region and returns, one cycle later, either
// the physical address or a prohibited cause. Assumes ATTR_W is 4 and
// the region index is the top RGN_BITS address bits.
module rgn_access_guard
    import rgn_guard_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int RGN_BITS = 3,
    parameter int ATTR_W   = 4,
    localparam int NUM_RGN = 1 << RGN_BITS,
    localparam int OFF_W   = ADDR_W - RGN_BITS,
    localparam int WORD_W  = NUM_RGN * ATTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_mode,
    input  logic [WORD_W-1:0]   cattr_word,
    input  logic                cfg_we,
    input  logic [RGN_BITS-1:0] cfg_idx,
    input  logic [RGN_BITS-1:0] cfg_base,
    input  logic [ATTR_W-1:0]   cfg_attr,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_kind,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic [CAUSE_W-1:0]  rsp_cause,
    output logic                rsp_rd,
    output logic                rsp_wr,
    output logic                rsp_ex,
    output logic [2:0]          rsp_cmode
);

    logic [RGN_BITS-1:0] rgn_idx;
    logic [RGN_BITS-1:0] ent_base;
    logic [ATTR_W-1:0]   ent_attr;
    logic [ATTR_W-1:0]   sel_attr;
    perm_t               perm;
    logic [CAUSE_W-1:0]  cause;
    logic [ADDR_W-1:0]   paddr;

    assign rgn_idx = req_addr[ADDR_W-1 -: RGN_BITS];

    rgn_entry_table #(
        .NUM_RGN (NUM_RGN),
        .IDX_W   (RGN_BITS),
        .BASE_W  (RGN_BITS),
        .ATTR_W  (ATTR_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_base (cfg_base),
        .wr_attr (cfg_attr),
        .rd_idx  (rgn_idx),
        .rd_base (ent_base),
        .rd_attr (ent_attr)
    );

    rgn_attr_source #(
        .NUM_RGN (NUM_RGN),
        .IDX_W   (RGN_BITS),
        .ATTR_W  (ATTR_W)
    ) u_src (
        .tbl_mode   (tbl_mode),
        .idx        (rgn_idx),
        .cattr_word (cattr_word),
        .tbl_attr   (ent_attr),
        .attr       (sel_attr)
    );

    rgn_perm_check u_chk_perm (
        .attr     (sel_attr),
        .from_tbl (tbl_mode),
        .kind     (req_kind),
        .perm     (perm),
        .cause    (cause)
    );

    // Form the physical address: translated in table mode, zero if denied.
    always_comb begin
        if (cause != CAUSE_OK)  paddr = '0;
        else if (tbl_mode)      paddr = {ent_base, req_addr[OFF_W-1:0]};
        else                    paddr = req_addr;
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_cause <= CAUSE_OK;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
            rsp_cmode <= CM_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr <= paddr;
                rsp_cause <= cause;
                rsp_rd    <= perm.rd;
                rsp_wr    <= perm.wr;
                rsp_ex    <= perm.ex;
                rsp_cmode <= perm.cm;
            end
        end
    end

endmodule

// File: rtl/rgn_access_guard_chk.sv
// Property checker for the region access guard, bound to the top.
// Relates request inputs to the registered response one cycle later.
module rgn_access_guard_chk
    import rgn_guard_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int RGN_BITS = 3,
    localparam int OFF_W   = ADDR_W - RGN_BITS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tbl_mode,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [1:0]         req_kind,
    input logic               rsp_valid,
    input logic [ADDR_W-1:0]  rsp_paddr,
    input logic [CAUSE_W-1:0] rsp_cause,
    input logic               rsp_rd,
    input logic               rsp_wr,
    input logic               rsp_ex,
    input logic [2:0]         rsp_cmode
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !rsp_valid); // R1

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2

    AST_STORE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd1 |=> (rsp_cause == CAUSE_OK) == rsp_wr); // R6

    AST_FETCH_NEEDS_EX: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd2 |=> (rsp_cause == CAUSE_OK) == rsp_ex); // R6

    AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind[1] == req_kind[0] |=>
            rsp_cause == CAUSE_OK || rsp_cause == CAUSE_LOAD); // R7

    AST_FETCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == 2'd2 |=>
            rsp_cause == CAUSE_OK || rsp_cause == CAUSE_FETCH); // R7

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_cause != CAUSE_OK ||
            rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])); // R8

    AST_WORD_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !tbl_mode |=> rsp_cause != CAUSE_OK ||
            rsp_paddr == $past(req_addr)); // R8

    AST_DENIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause != CAUSE_OK |-> rsp_paddr == '0); // R8

    AST_ISOLATE_NO_EX: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cmode == 3'd4 |-> rsp_rd && rsp_wr && !rsp_ex); // R4

    AST_NONE_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cmode == 3'd0 |-> !rsp_rd && !rsp_wr && !rsp_ex); // R5

endmodule

bind rgn_access_guard rgn_access_guard_chk #(
    .ADDR_W   (ADDR_W),
    .RGN_BITS (RGN_BITS)
) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tbl_mode  (tbl_mode),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_cause (rsp_cause),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr),
    .rsp_ex    (rsp_ex),
    .rsp_cmode (rsp_cmode)
);

// File: tb/rgn_access_guard_test.sv
module rgn_access_guard_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tbl_mode;
    logic [31:0] cattr_word;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [2:0]  cfg_base;
    logic [3:0]  cfg_attr;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_kind;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [5:0]  rsp_cause;
    logic        rsp_rd, rsp_wr, rsp_ex;
    logic [2:0]  rsp_cmode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural model state of the region table.
    int m_base [8];
    int m_attr [8];

    always #2 clk = ~clk;

    rgn_access_guard uut (
        .clk(clk), .rst_n(rst_n), .tbl_mode(tbl_mode), .cattr_word(cattr_word),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_attr(cfg_attr),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_cmode(rsp_cmode)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    // Expected {rd,wr,ex,cmode} for a code (R4, R5).
    function automatic logic [5:0] exp_perm(int code, bit tbl);
        case (code)
            0:  return {3'b110, 3'd1};
            1:  return {3'b111, 3'd1};
            2:  return {3'b111, 3'd3};
            3:  return {3'b001, 3'd2};
            4:  return {3'b111, 3'd2};
            5:  return tbl ? {3'b111, 3'd2} : 6'd0;
            14: return {3'b110, 3'd4};
            default: return 6'd0;
        endcase
    endfunction

    // One clock: drive at negedge, predict, update model at edge, compare.
    task automatic step(bit tbl, logic [31:0] cw, bit we, int widx, int wbase, int wattr,
                        bit v, logic [31:0] addr, int kind, string tag);
        logic [5:0]  p;
        logic [5:0]  ecause;
        logic [31:0] epa;
        int          r;
        bit          need;
        tbl_mode = tbl; cattr_word = cw;
        cfg_we = we; cfg_idx = widx[2:0]; cfg_base = wbase[2:0]; cfg_attr = wattr[3:0];
        req_valid = v; req_addr = addr; req_kind = kind[1:0];
        r = int'(addr[31:29]);
        p = exp_perm(tbl ? m_attr[r] : int'(cw[r*4 +: 4]), tbl);
        if (kind == 1)      need = p[4];
        else if (kind == 2) need = p[3];
        else                need = p[5];
        ecause = need ? 6'd0 : (kind == 1 ? 6'd29 : (kind == 2 ? 6'd20 : 6'd28));
        if (!need)    epa = 32'd0;
        else if (tbl) epa = {3'(m_base[r]), addr[28:0]};
        else          epa = addr;
        @(posedge clk);
        if (we) begin m_base[widx] = wbase; m_attr[widx] = wattr; end
        @(negedge clk);
        checks++;
        if (rsp_valid !== v) begin
            errors++;
            $display("FAIL R2 %s: rsp_valid actual=%0b expected=%0b", tag, rsp_valid, v);
        end else if (v) begin
            checks++;
            if ({rsp_cause, rsp_paddr, rsp_rd, rsp_wr, rsp_ex, rsp_cmode} !== {ecause, epa, p}) begin
                errors++;
                $display("FAIL %s: cause/paddr/rwx/cm actual=%0d/%h/%b/%0d expected=%0d/%h/%b/%0d",
                         tag, rsp_cause, rsp_paddr, {rsp_rd, rsp_wr, rsp_ex}, rsp_cmode,
                         ecause, epa, p[5:3], p[2:0]);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; tbl_mode = 1'b0; cattr_word = '0; cfg_we = 1'b0; cfg_idx = '0;
        cfg_base = '0; cfg_attr = '0; req_valid = 1'b0; req_addr = '0; req_kind = '0;
        for (int i = 0; i < 8; i++) begin m_base[i] = i; m_attr[i] = 2; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_valid in reset actual=%0b expected=0", rsp_valid);
        end
        rst_n = 1'b1;

        // R1: reset table is identity with code 2 in every region.
        for (int r = 0; r < 8; r++)
            step(1, 32'h0, 0, 0, 0, 0, 1, {3'(r), 29'h0ABC_1234}, r % 3, "R1 reset entry");

        // R2: idle cycle produces no response.
        step(1, 32'h0, 0, 0, 0, 0, 0, 32'h0, 0, "R2 idle");

        // R4 R5 R6 R7 R3: every code in word mode, placed at varying nibbles.
        for (int c = 0; c < 16; c++)
            for (int k = 0; k < 4; k++) begin
                int r = (c + k) % 8;
                logic [31:0] cw = 32'hFFFF_FFFF;
                cw[r*4 +: 4] = 4'(c);
                step(0, cw, 0, 0, 0, 0, 1, {3'(r), 29'(c * 4099 + k)}, k, "R4 R5 R6 R7 word");
            end

        // R9 R8 R5: write every code into an entry, then access it in table mode.
        for (int c = 0; c < 16; c++) begin
            int r = c % 8;
            step(1, 32'h0, 1, r, 7 - r, c, 0, 32'h0, 0, "R9 write");
            for (int k = 0; k < 3; k++)
                step(1, 32'h5555_5555, 0, 0, 0, 0, 1, {3'(r), 29'(32'h1357_9BDF + c * k)}, k,
                     "R8 R5 R6 table");
        end

        // R9: request in the same cycle as a write to its entry sees old value.
        step(1, 32'h0, 0, 0, 0, 0, 0, 32'h0, 0, "R9 idle");
        step(1, 32'h0, 1, 3, 3, 2, 0, 32'h0, 0, "R9 prep");
        step(1, 32'h0, 1, 3, 6, 3, 1, 32'h6000_0010, 0, "R9 same-cycle old entry");
        step(1, 32'h0, 0, 0, 0, 0, 1, 32'h6000_0010, 0, "R9 new entry denies load");
        step(1, 32'h0, 0, 0, 0, 0, 1, 32'h6000_0010, 2, "R9 new entry fetch");

        // R10 R3: table and word sources differ for the same region.
        step(0, 32'h0003_0000, 0, 0, 0, 0, 1, 32'h8000_0004, 1, "R10 word store on exec-only");
        step(1, 32'h0003_0000, 0, 0, 0, 0, 1, 32'h8000_0004, 1, "R3 table same region");

        // R6: kind 3 behaves as a load.
        step(0, 32'h3333_3333, 0, 0, 0, 0, 1, 32'hE000_0000, 3, "R6 kind3 as load");
        step(0, 32'h1111_1111, 0, 0, 0, 0, 1, 32'hE000_0000, 3, "R6 kind3 granted");

        // Pseudo-random mix of modes, words, writes and requests.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a = $urandom;
            logic [31:0] w = $urandom;
            int s = int'($urandom % 64);
            step(s[0], w, s[1], s % 8, (s / 8) % 8, int'(w[7:4]), s[2] | s[3], a, int'(a[1:0]),
                 "R3 R8 mixed");
        end

        finish_run();
    end

endmodule